// File: doc/BRIEF.md
# Ethernet Receive Frame Packer and Word Reader

This block sits between a receive byte source and a processor-side data register. Each incoming frame is announced by a start handshake that carries its payload length, followed by the payload bytes under a valid/ready handshake. If reception is enabled and the store has room for the complete framed record, the block writes the record into a byte-addressed receive store:

- a constant marker word;
- an info word holding the stored length and a good-status flag;
- the payload, zero-padded to the 60-byte minimum;
- a CRC-32 word;
- zero fill up to a 4-byte boundary.

If either condition fails, the payload bytes are accepted and discarded.

Software drains stored frames one 32-bit word per read request. The reader tracks where it stands inside the current record: marker, then info, then body. It counts the body down using the length carried in the info word. When the last word of a record has been read, it returns to the marker position and the held-frame count drops by one. Each stored frame raises a sticky receive interrupt flag until it is cleared.

Writer states: `W_IDLE` (start accepted here; goes to `W_MAGIC` when the frame is accepted, to `W_DROP` when it is refused with a nonzero length, otherwise stays), `W_MAGIC` → `W_INFO` after 4 bytes, `W_INFO` → `W_DATA` (or `W_PAD` for an empty payload), `W_DATA` → `W_PAD` if the payload is short or `W_CRC` otherwise, `W_PAD` → `W_CRC` at 60 bytes, `W_CRC` → `W_FILL` or `W_IDLE` after 4 bytes, `W_FILL` → `W_IDLE`, `W_DROP` → `W_IDLE` after the last discarded byte. Reader states: `R_MAGIC` → `R_INFO` → `R_BODY` → `R_MAGIC` on the final word; each step advances only on a read while a frame is held.

Top module: `eth_rx_packer`

## Requirements
- R1: A frame is stored only if `rx_en` is 1 when its start is accepted and free space ≥ round-up-to-4(max(len,60)+12) bytes; otherwise its payload bytes are consumed, nothing is stored, and the frame count is unchanged.
- R2: Payloads shorter than 60 bytes are followed by zero bytes up to 60 stored payload bytes (padded length P = max(len,60)).
- R3: Record word 0 is 0x0143414D; word 1 has bits [15:0] = P+4, bit 16 = 1 (good status), and all other bits 0.
- R4: The CRC word follows the P payload bytes. It is the reflected CRC-32 (polynomial 0xEDB88320, register preset to all ones, result complemented) over those P bytes, stored least significant byte first.
- R5: Zero bytes follow the CRC so that the record length is round-up-to-4(P+12) bytes.
- R6: Storing a frame increments `frame_count` and sets `rx_irq` on the cycle the last record byte is written. `irq_clr` clears `rx_irq`; a same-cycle set wins over the clear.
- R7: A read request while `frame_count` is 0 gives `rd_data` = 0 one cycle later and does not consume stored data.
- R8: The read after the info word's rounded-up length is used up completes the record: `frame_count` decrements, and the next read returns the next record's marker word.
- R9: Each read word is built from four consecutive stored bytes, the earliest in bits [7:0]; `rd_data` is valid the cycle after `rd_req`.
- R10: After reset, `frame_count` = 0, `rx_irq` = 0, `start_ready` = 1 and `in_ready` = 0.
- R11: `in_ready` is 0 while the marker, info, pad, CRC and fill bytes are being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Reception enable, sampled at frame start |
| start_valid | input | 1 | Frame start request |
| start_len | input | LEN_W | Payload length in bytes for the frame being started |
| start_ready | output | 1 | Start can be accepted (writer idle) |
| in_valid | input | 1 | Payload byte valid |
| in_byte | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte accepted on this edge when valid |
| rd_req | input | 1 | Read one word from the data register |
| rd_data | output | 32 | Word returned for the previous read request |
| frame_count | output | CW | Number of complete frames held |
| irq_clr | input | 1 | Clear the receive interrupt flag |
| rx_irq | output | 1 | Sticky receive interrupt flag |

## Verification
A wrong writer position shows up directly at the ports. A miscounted pad or fill moves every later word of the record and of the next record. The reader's info word or body count is then off, so the frame count drops one read early or late, or the next marker read returns body data; both appear within one record of the fault. A CRC or byte-lane error corrupts exactly the words that carry it, on the first read of that record. A wrong free-space comparison shows up at the frame count during a fill-to-capacity run.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

    localparam logic [31:0] RX_MARKER = 32'h0143414D;
    localparam logic [31:0] CRC_POLY  = 32'hEDB88320;

    typedef enum logic [2:0] {
        W_IDLE, W_MAGIC, W_INFO, W_DATA, W_PAD, W_CRC, W_FILL, W_DROP
    } wr_state_t;

    typedef enum logic [1:0] {
        R_MAGIC, R_INFO, R_BODY
    } rd_state_t;

    function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] b);
        logic [31:0] c;
        c = c_in ^ {24'd0, b};
        for (int k = 0; k < 8; k++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        end
        return c;
    endfunction

    function automatic logic [15:0] round4(input logic [15:0] v);
        logic [15:0] s;
        s = v + 16'd3;
        return {s[15:2], 2'b00};
    endfunction

endpackage

// File: rtl/rxpk_store.sv
module rxpk_store #(
    parameter int DEPTH = 2048,
    localparam int AW    = $clog2(DEPTH),
    localparam int WORDS = DEPTH / 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_byte,
    input  logic          pop,
    output logic [31:0]   rd_word,
    output logic [AW:0]   free_bytes
);
    logic [31:0]   mem [WORDS];
    logic [AW-1:0] wptr_q;
    logic [AW-3:0] ridx_q;
    logic [AW:0]   used_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wptr_q[AW-1:2]][{wptr_q[1:0], 3'b000} +: 8] <= wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            ridx_q <= '0;
            used_q <= '0;
        end else begin
            if (wr_en) wptr_q <= wptr_q + 1'b1;
            if (pop)   ridx_q <= ridx_q + 1'b1;
            used_q <= used_q + (wr_en ? (AW+1)'(1) : '0) - (pop ? (AW+1)'(4) : '0);
        end
    end

    assign rd_word    = mem[ridx_q];
    assign free_bytes = (AW+1)'(DEPTH) - used_q;

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (free_bytes != '0));
    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (used_q >= (AW+1)'(4)));

endmodule

// File: rtl/rxpk_writer.sv
module rxpk_writer
    import rxpk_pkg::*;
#(
    parameter int LEN_W       = 11,
    parameter int AW          = 11,
    parameter int MIN_PAYLOAD = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic [AW:0]      free_bytes,
    input  logic             start_valid,
    input  logic [LEN_W-1:0] start_len,
    output logic             start_ready,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    output logic             wr_en,
    output logic [7:0]       wr_byte,
    output logic             frame_done
);
    wr_state_t   state_q, state_d;
    logic [15:0] pos_q, pos_d;
    logic [15:0] len_q, pad_q;
    logic [1:0]  fill_q;
    logic [31:0] crc_q;

    logic [15:0] len_in, pad_in, total_in;
    logic        fits;
    logic [31:0] info_word;

    assign len_in    = 16'(start_len);
    assign pad_in    = (len_in < 16'(MIN_PAYLOAD)) ? 16'(MIN_PAYLOAD) : len_in;
    assign total_in  = round4(pad_in + 16'd12);
    assign fits      = (16'(free_bytes) >= total_in);
    assign info_word = {15'd0, 1'b1, pad_q + 16'd4};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        unique case (state_q)
            W_IDLE: begin
                pos_d = '0;
                if (start_valid) begin
                    if (rx_en && fits)        state_d = W_MAGIC;
                    else if (len_in != '0)    state_d = W_DROP;
                end
            end
            W_MAGIC: begin
                if (pos_q == 16'd3) begin state_d = W_INFO; pos_d = '0; end
                else pos_d = pos_q + 16'd1;
            end
            W_INFO: begin
                if (pos_q == 16'd3) begin
                    pos_d   = '0;
                    state_d = (len_q == '0) ? W_PAD : W_DATA;
                end else pos_d = pos_q + 16'd1;
            end
            W_DATA: begin
                if (in_valid) begin
                    if (pos_q == len_q - 16'd1) begin
                        if (len_q < pad_q) begin state_d = W_PAD; pos_d = pos_q + 16'd1; end
                        else begin state_d = W_CRC; pos_d = '0; end
                    end else pos_d = pos_q + 16'd1;
                end
            end
            W_PAD: begin
                if (pos_q == pad_q - 16'd1) begin state_d = W_CRC; pos_d = '0; end
                else pos_d = pos_q + 16'd1;
            end
            W_CRC: begin
                if (pos_q == 16'd3) begin
                    pos_d   = '0;
                    state_d = (fill_q == 2'd0) ? W_IDLE : W_FILL;
                end else pos_d = pos_q + 16'd1;
            end
            W_FILL: begin
                if (pos_q[1:0] == fill_q - 2'd1) begin state_d = W_IDLE; pos_d = '0; end
                else pos_d = pos_q + 16'd1;
            end
            W_DROP: begin
                if (in_valid) begin
                    if (pos_q == len_q - 16'd1) begin state_d = W_IDLE; pos_d = '0; end
                    else pos_d = pos_q + 16'd1;
                end
            end
            default: begin
                state_d = W_IDLE;
                pos_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        start_ready = 1'b0;
        in_ready    = 1'b0;
        wr_en       = 1'b0;
        wr_byte     = 8'd0;
        frame_done  = 1'b0;
        unique case (state_q)
            W_IDLE:  start_ready = 1'b1;
            W_MAGIC: begin wr_en = 1'b1; wr_byte = 8'(RX_MARKER >> {pos_q[1:0], 3'b000}); end
            W_INFO:  begin wr_en = 1'b1; wr_byte = 8'(info_word >> {pos_q[1:0], 3'b000}); end
            W_DATA:  begin in_ready = 1'b1; wr_en = in_valid; wr_byte = in_byte; end
            W_PAD:   wr_en = 1'b1;
            W_CRC: begin
                wr_en      = 1'b1;
                wr_byte    = 8'(~crc_q >> {pos_q[1:0], 3'b000});
                frame_done = (pos_q == 16'd3) && (fill_q == 2'd0);
            end
            W_FILL: begin
                wr_en      = 1'b1;
                frame_done = (pos_q[1:0] == fill_q - 2'd1);
            end
            W_DROP:  in_ready = 1'b1;
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            pad_q  <= '0;
            fill_q <= '0;
            crc_q  <= '1;
        end else if (state_q == W_IDLE && start_valid) begin
            len_q  <= len_in;
            pad_q  <= pad_in;
            fill_q <= 2'd0 - pad_in[1:0];
            crc_q  <= '1;
        end else if (wr_en && (state_q == W_DATA || state_q == W_PAD)) begin
            crc_q  <= crc_step(crc_q, wr_byte);
        end
    end

    // R1
    refused_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && start_ready && !rx_en) |=> !wr_en);
    // R11
    hdr_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && start_ready && rx_en && fits) |=> (!in_ready && wr_en));

endmodule

// File: rtl/rxpk_reader.sv
module rxpk_reader
    import rxpk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_req,
    input  logic        have_frame,
    input  logic [31:0] word_in,
    output logic        pop,
    output logic [31:0] rd_data,
    output logic        frame_done
);
    rd_state_t   state_q, state_d;
    logic [15:0] rem_q, rem_d;
    logic [31:0] data_q;
    logic [15:0] body_len;

    assign pop      = rd_req && have_frame;
    assign body_len = round4(word_in[15:0]);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= R_MAGIC;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    // next state
    always_comb begin
        state_d    = state_q;
        rem_d      = rem_q;
        frame_done = 1'b0;
        unique case (state_q)
            R_MAGIC: if (pop) state_d = R_INFO;
            R_INFO: begin
                if (pop) begin
                    rem_d = body_len;
                    if (body_len == '0) begin state_d = R_MAGIC; frame_done = 1'b1; end
                    else state_d = R_BODY;
                end
            end
            R_BODY: begin
                if (pop) begin
                    rem_d = rem_q - 16'd4;
                    if (rem_q <= 16'd4) begin
                        rem_d      = '0;
                        state_d    = R_MAGIC;
                        frame_done = 1'b1;
                    end
                end
            end
            default: state_d = R_MAGIC;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (pop)    data_q <= word_in;
        else if (rd_req) data_q <= '0;
    end

    assign rd_data = data_q;

    // R7
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !have_frame) |=> (rd_data == '0));

endmodule

// File: rtl/eth_rx_packer.sv
module eth_rx_packer #(
    parameter int DEPTH       = 2048,
    parameter int LEN_W       = 11,
    parameter int MIN_PAYLOAD = 60,
    localparam int AW         = $clog2(DEPTH),
    localparam int CW         = AW - 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             start_valid,
    input  logic [LEN_W-1:0] start_len,
    output logic             start_ready,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    input  logic             rd_req,
    output logic [31:0]      rd_data,
    output logic [CW-1:0]    frame_count,
    input  logic             irq_clr,
    output logic             rx_irq
);
    logic        wr_en, pop, wr_done, rd_done;
    logic [7:0]  wr_byte;
    logic [31:0] rd_word;
    logic [AW:0] free_bytes;
    logic [CW-1:0] count_q;
    logic        irq_q;

    rxpk_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
        .pop(pop), .rd_word(rd_word), .free_bytes(free_bytes)
    );

    rxpk_writer #(.LEN_W(LEN_W), .AW(AW), .MIN_PAYLOAD(MIN_PAYLOAD)) u_writer (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .free_bytes(free_bytes),
        .start_valid(start_valid), .start_len(start_len), .start_ready(start_ready),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .wr_en(wr_en), .wr_byte(wr_byte), .frame_done(wr_done)
    );

    rxpk_reader u_reader (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .have_frame(count_q != '0),
        .word_in(rd_word), .pop(pop), .rd_data(rd_data), .frame_done(rd_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            count_q <= count_q + (wr_done ? CW'(1) : '0) - (rd_done ? CW'(1) : '0);
            if (wr_done)      irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;
        end
    end

    assign frame_count = count_q;
    assign rx_irq      = irq_q;

    // R6
    irq_on_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> rx_irq);
    // R8
    count_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (frame_count != '0));
    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && !rd_done) |=> (frame_count == $past(frame_count) + CW'(1)));

endmodule

// File: tb/eth_rx_packer_test.sv
module eth_rx_packer_test;
    localparam int DEPTH = 2048;
    localparam int LEN_W = 11;
    localparam int CW    = $clog2(DEPTH) - 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0;
    logic start_valid = 1'b0;
    logic [LEN_W-1:0] start_len = '0;
    logic start_ready;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic in_ready;
    logic rd_req = 1'b0;
    logic [31:0] rd_data;
    logic [CW-1:0] frame_count;
    logic irq_clr = 1'b0;
    logic rx_irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] eb [0:1599];

    always #4 clk = ~clk;

    eth_rx_packer #(.DEPTH(DEPTH), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .start_valid(start_valid),
        .start_len(start_len), .start_ready(start_ready), .in_valid(in_valid),
        .in_byte(in_byte), .in_ready(in_ready), .rd_req(rd_req), .rd_data(rd_data),
        .frame_count(frame_count), .irq_clr(irq_clr), .rx_irq(rx_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pay(input int len, input int i);
        return 8'((i * 13 + len * 5 + 1) & 255);
    endfunction

    task automatic build(input int len, output int nb);
        int p;
        logic [31:0] crc, info;
        p = (len < 60) ? 60 : len;
        info = 32'h0001_0000 | 32'(p + 4);
        for (int k = 0; k < 4; k++) begin
            eb[k]     = 8'(32'h0143414D >> (8 * k));
            eb[4 + k] = 8'(info >> (8 * k));
        end
        crc = 32'hFFFF_FFFF;
        for (int i = 0; i < p; i++) begin
            eb[8 + i] = (i < len) ? pay(len, i) : 8'd0;
            crc = crc ^ {24'd0, eb[8 + i]};
            for (int b = 0; b < 8; b++) crc = crc[0] ? ((crc >> 1) ^ 32'hEDB88320) : (crc >> 1);
        end
        crc = ~crc;
        for (int k = 0; k < 4; k++) eb[8 + p + k] = 8'(crc >> (8 * k));
        nb = ((p + 12 + 3) / 4) * 4;
        for (int k = p + 12; k < nb; k++) eb[k] = 8'd0;
    endtask

    task automatic send(input int len, input bit expect_store);
        @(negedge clk);
        start_valid = 1'b1;
        start_len = LEN_W'(len);
        while (!start_ready) @(negedge clk);
        @(negedge clk);
        start_valid = 1'b0;
        if (expect_store && len > 0) chk("R11 in_ready during header", {31'd0, in_ready}, 32'd0);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_byte = pay(len, i);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        while (!start_ready) @(negedge clk);
    endtask

    task automatic rd(output logic [31:0] v);
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        v = rd_data;
    endtask

    task automatic read_frame(input int len, input int cnt_before);
        int nb, p;
        logic [31:0] v, e;
        build(len, nb);
        p = (len < 60) ? 60 : len;
        for (int w = 0; w < nb / 4; w++) begin
            int b;
            b = 4 * w;
            e = {eb[b + 3], eb[b + 2], eb[b + 1], eb[b]};
            rd(v);
            if (b < 8)            chk($sformatf("R3 len %0d word %0d", len, w), v, e);
            else if (b - 8 < len) chk($sformatf("R9 len %0d word %0d", len, w), v, e);
            else if (b - 8 < p)   chk($sformatf("R2 len %0d word %0d", len, w), v, e);
            else                  chk($sformatf("R4 R5 len %0d word %0d", len, w), v, e);
            if (w == nb / 4 - 2)
                chk("R8 count before last word", 32'(frame_count), 32'(cnt_before));
        end
        chk($sformatf("R8 count after len %0d", len), 32'(frame_count), 32'(cnt_before - 1));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 frame_count", 32'(frame_count), 32'd0);
        chk("R10 rx_irq", {31'd0, rx_irq}, 32'd0);
        chk("R10 start_ready", {31'd0, start_ready}, 32'd1);
        chk("R10 in_ready", {31'd0, in_ready}, 32'd0);

        // R7 empty read
        rd(v);
        chk("R7 empty read", v, 32'd0);
        chk("R7 count after empty read", 32'(frame_count), 32'd0);

        // R1 disabled reception drops the frame
        send(10, 1'b0);
        chk("R1 disabled drop count", 32'(frame_count), 32'd0);
        rd(v);
        chk("R1 R7 read after drop", v, 32'd0);

        rx_en = 1'b1;
        // sweep short, boundary and long lengths
        for (int len = 0; len <= 70; len++) begin
            send(len, 1'b1);
            chk($sformatf("R6 count len %0d", len), 32'(frame_count), 32'd1);
            chk($sformatf("R6 irq len %0d", len), {31'd0, rx_irq}, 32'd1);
            @(negedge clk); irq_clr = 1'b1;
            @(negedge clk); irq_clr = 1'b0;
            chk("R6 irq cleared", {31'd0, rx_irq}, 32'd0);
            read_frame(len, 1);
            rd(v);
            chk("R7 read past end", v, 32'd0);
        end
        send(127, 1'b1);
        send(1514, 1'b1);
        chk("R6 two frames held", 32'(frame_count), 32'd2);
        read_frame(127, 2);
        read_frame(1514, 1);

        // R1 capacity: 28 records of 72 bytes leave 32 bytes free
        for (int f = 0; f < 28; f++) send(60, 1'b1);
        chk("R1 filled count", 32'(frame_count), 32'd28);
        send(60, 1'b0);
        chk("R1 full drop count", 32'(frame_count), 32'd28);
        read_frame(60, 28);
        send(61, 1'b1);
        chk("R1 accept after space freed", 32'(frame_count), 32'd28);
        for (int f = 0; f < 27; f++) read_frame(60, 28 - f);
        read_frame(61, 1);
        rd(v);
        chk("R7 drained read", v, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule